// File: doc/BRIEF.md
# I2C Controller Control-Flag Register Block

This block keeps the control flags of an I2C controller: interface enable, interrupt enable, start request, assert-acknowledge and the interrupt flag. Software reaches the flags through two write ports of a simple register bus. On the raise port, each 1 sets its flag. On the drop port, each 1 clears its flag. A 0 on either port leaves the flag alone, so no read-modify-write is needed.

The bus engine reports two kinds of event. A status-change strobe comes with the new status code, and it raises the interrupt flag. A start-sent strobe retires the start request. The block drives the interrupt request from the interrupt flag and the interrupt enable. It also gives the engine a qualifier that permits slave responses. A write-only soft-reset register accepts one key value. That value clears every flag and sends a one-cycle reset pulse to the rest of the controller.

Top module: `i2c_ctrl_flags`

## Requirements
- R1: While `rst_n` is low at a clock edge, all flags, `irq`, `slave_resp_en` and `srst_pulse` are 0 after that edge.
- R2: The flag bit positions are enable = bit 0, interrupt enable = bit 1, start request = bit 2, assert-acknowledge = bit 3 and interrupt flag = bit 4. These positions apply to `flags`, `set_bits` and `clr_bits`. A write with `set_we` high sets every flag whose `set_bits` bit is 1, from the next clock edge. Bits written as 0 leave their flags unchanged.
- R3: A write with `clr_we` high clears every flag whose `clr_bits` bit is 1, from the next clock edge. Bits written as 0 leave their flags unchanged.
- R4: When a flag is asked to set and to clear in the same cycle, it ends up 0. This holds for any mix of software and hardware causes.
- R5: A `stat_chg` strobe whose `stat_code` is not 0xF8 sets the interrupt flag at the next edge. A strobe with code 0xF8 leaves the interrupt flag unchanged. No hardware event ever clears the interrupt flag.
- R6: `irq` is high exactly when both the interrupt flag and the interrupt enable are set.
- R7: A `start_sent` strobe clears the start request at the next edge. A set-port write with bit 2 at 0 does not clear it.
- R8: A write of 0x07 to the soft-reset port clears all flags at the next edge. It also drives `srst_pulse` high for the one cycle after that edge. Any other value written there has no effect on the flags or on `srst_pulse`.
- R9: `slave_resp_en` is high only when both enable and assert-acknowledge are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_we | input | 1 | Write strobe of the raise port |
| set_bits | input | 5 | Raise mask, 1 sets the flag |
| clr_we | input | 1 | Write strobe of the drop port |
| clr_bits | input | 5 | Drop mask, 1 clears the flag |
| srst_we | input | 1 | Write strobe of the soft-reset port |
| srst_data | input | 8 | Soft-reset value, 0x07 fires |
| stat_chg | input | 1 | Status-change strobe from the bus engine |
| stat_code | input | 8 | New status code that comes with `stat_chg` |
| start_sent | input | 1 | START-condition-sent strobe from the bus engine |
| flags | output | 5 | Current flag values |
| irq | output | 1 | Interrupt request |
| slave_resp_en | output | 1 | Slave responses permitted |
| srst_pulse | output | 1 | One-cycle controller reset pulse |

## Verification
The bench drives a raise and a drop of the same bit in one cycle, for both the start request and the interrupt flag. A design that let the set win would leave those flags at 1. It sends status code 0xF8 and an idle cycle after an interrupt. A design that raised the flag on every strobe, or that let hardware drop it, would show the wrong interrupt flag and the wrong `irq`. It writes all-zero masks to both ports and the wrong key to the soft-reset port. A design that treated a write as a full load, or that decoded the key loosely, would lose flags or pulse the reset. It also sends a soft reset in the same cycle as a raise, which must still clear every flag.

// File: rtl/i2cflag_pkg.sv
// Package: shared flag positions and count for the control-flag block.
// Assumes the set, clear and flag vectors all use these positions.
package i2cflag_pkg;
    localparam int NFLAG = 5;
    localparam int B_EN  = 0;
    localparam int B_IEN = 1;
    localparam int B_STA = 2;
    localparam int B_AA  = 3;
    localparam int B_SI  = 4;
endpackage

// File: rtl/flag_cell.sv
// One control flag. Software and hardware can each set or clear it, and
// any clear beats any set. Wipe (soft reset) beats everything.
// Assumes all request inputs are single-cycle, synchronous to clk.
module flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic wipe,
    input  logic sw_set,
    input  logic sw_clr,
    input  logic hw_set,
    input  logic hw_clr,
    output logic q
);
    logic drop;
    logic raise;

    // Gather the clear and set causes.
    always_comb begin
        drop  = sw_clr | hw_clr;
        raise = sw_set | hw_set;
    end

    // Flag register with priority wipe > clear > set > hold.
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            q <= 1'b0;
        end else if (drop) begin
            q <= 1'b0;
        end else if (raise) begin
            q <= 1'b1;
        end
    end

    // R4: a clear request always leaves the flag at 0.
    a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr || hw_clr) |=> !q);

    // R2: an uncontested set leaves the flag at 1.
    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (raise && !sw_clr && !hw_clr && !wipe) |=> q);
endmodule

// File: rtl/srst_decode.sv
// Soft-reset key decoder. A write of KEY gives a combinational hit and a
// registered one-cycle pulse. Other values are ignored.
// Assumes one write per strobe cycle.
module srst_decode #(
    parameter int          DW  = 8,
    parameter logic [DW-1:0] KEY = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] data,
    output logic          hit,
    output logic          pulse
);
    // Exact key compare.
    always_comb begin
        hit = we && (data == KEY);
    end

    // Register the hit into the outgoing pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= hit;
        end
    end

    // R8: a write without the key never produces a pulse.
    a_r8_wrong_key_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!we || data != KEY) |=> !pulse);
endmodule

// File: rtl/stat_event.sv
// Turns a status-change strobe into an interrupt-flag raise request.
// A change into the idle code does not raise.
// Assumes stat_code is valid whenever stat_chg is high.
module stat_event #(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] IDLE = 8'hF8
) (
    input  logic          stat_chg,
    input  logic [DW-1:0] stat_code,
    output logic          si_raise
);
    // Qualify the strobe by the code.
    always_comb begin
        si_raise = stat_chg && (stat_code != IDLE);
    end
endmodule

// File: rtl/i2c_ctrl_flags.sv
// Control-flag register block of an I2C controller. It has a raise port
// and a drop port that act only on 1 bits, hardware set/clear for the
// interrupt and start-request flags, a soft-reset key register, and the
// interrupt and slave-response outputs.
// Assumes all strobes are single-cycle, synchronous to clk.
module i2c_ctrl_flags #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] IDLE_CODE = 8'hF8,
    parameter logic [DW-1:0] SRST_KEY  = 8'h07
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          set_we,
    input  logic [i2cflag_pkg::NFLAG-1:0] set_bits,
    input  logic                          clr_we,
    input  logic [i2cflag_pkg::NFLAG-1:0] clr_bits,
    input  logic                          srst_we,
    input  logic [DW-1:0]                 srst_data,
    input  logic                          stat_chg,
    input  logic [DW-1:0]                 stat_code,
    input  logic                          start_sent,
    output logic [i2cflag_pkg::NFLAG-1:0] flags,
    output logic                          irq,
    output logic                          slave_resp_en,
    output logic                          srst_pulse
);
    import i2cflag_pkg::*;

    localparam int NF = NFLAG;

    logic          wipe;
    logic          si_raise;
    logic [NF-1:0] sw_set_v;
    logic [NF-1:0] sw_clr_v;
    logic [NF-1:0] hw_set_v;
    logic [NF-1:0] hw_clr_v;

    srst_decode #(.DW(DW), .KEY(SRST_KEY)) i_srst (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (srst_we),
        .data  (srst_data),
        .hit   (wipe),
        .pulse (srst_pulse)
    );

    stat_event #(.DW(DW), .IDLE(IDLE_CODE)) i_stat (
        .stat_chg  (stat_chg),
        .stat_code (stat_code),
        .si_raise  (si_raise)
    );

    // Gate the software masks with their strobes.
    always_comb begin
        sw_set_v = set_we ? set_bits : '0;
        sw_clr_v = clr_we ? clr_bits : '0;
    end

    // Route the hardware events to their own flags.
    always_comb begin
        hw_set_v        = '0;
        hw_clr_v        = '0;
        hw_set_v[B_SI]  = si_raise;
        hw_clr_v[B_STA] = start_sent;
    end

    for (genvar i = 0; i < NF; i++) begin : g_flag
        flag_cell i_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .wipe   (wipe),
            .sw_set (sw_set_v[i]),
            .sw_clr (sw_clr_v[i]),
            .hw_set (hw_set_v[i]),
            .hw_clr (hw_clr_v[i]),
            .q      (flags[i])
        );
    end

    // Derived outputs.
    always_comb begin
        irq           = flags[B_SI] & flags[B_IEN];
        slave_resp_en = flags[B_EN] & flags[B_AA];
    end

    // R1: coming out of reset, every flag is clear.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flags == '0));

    // R7: a start-sent event retires the start request.
    a_r7_start_drop: assert property (@(posedge clk) disable iff (!rst_n)
        start_sent |=> !flags[B_STA]);

    // R5: the idle code does not raise the interrupt flag.
    a_r5_idle_no_si: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_chg && stat_code == IDLE_CODE && !flags[B_SI]
         && !(set_we && set_bits[B_SI])) |=> !flags[B_SI]);

    // R5: hardware never clears the interrupt flag.
    a_r5_si_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[B_SI] && !(clr_we && clr_bits[B_SI]) && !wipe) |=> flags[B_SI]);

    // R6: a rising interrupt request needs the interrupt flag set.
    a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (flags[B_SI] && flags[B_IEN]));

    // R8: while the reset pulse is high, all flags have been wiped.
    a_r8_pulse_wipes: assert property (@(posedge clk) disable iff (!rst_n)
        srst_pulse |-> (flags == '0));

    // R9: the slave response never goes high without assert-acknowledge.
    a_r9_slave_needs_aa: assert property (@(posedge clk) disable iff (!rst_n)
        slave_resp_en |-> flags[B_AA]);
endmodule

// File: tb/test_i2c_ctrl_flags.sv
// Scoreboard bench: the driver pushes the expected outputs for each cycle,
// and the monitor pops and compares them after the following clock edge.
module test_i2c_ctrl_flags;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_we = 1'b0;
    logic [4:0] set_bits = '0;
    logic       clr_we = 1'b0;
    logic [4:0] clr_bits = '0;
    logic       srst_we = 1'b0;
    logic [7:0] srst_data = '0;
    logic       stat_chg = 1'b0;
    logic [7:0] stat_code = '0;
    logic       start_sent = 1'b0;
    logic [4:0] flags;
    logic       irq;
    logic       slave_resp_en;
    logic       srst_pulse;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctrl_flags i_i2c_ctrl_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_we        (set_we),
        .set_bits      (set_bits),
        .clr_we        (clr_we),
        .clr_bits      (clr_bits),
        .srst_we       (srst_we),
        .srst_data     (srst_data),
        .stat_chg      (stat_chg),
        .stat_code     (stat_code),
        .start_sent    (start_sent),
        .flags         (flags),
        .irq           (irq),
        .slave_resp_en (slave_resp_en),
        .srst_pulse    (srst_pulse)
    );

    // Drive one cycle of stimulus and queue the expected outputs.
    // f: flags, i: irq, s: slave_resp_en, p: srst_pulse.
    task automatic step(input logic sw, input logic [4:0] sb,
                        input logic cw, input logic [4:0] cb,
                        input logic rw, input logic [7:0] rd,
                        input logic sc, input logic [7:0] code,
                        input logic ss,
                        input logic [4:0] f, input logic i,
                        input logic s, input logic p, input string tag);
        @(negedge clk);
        set_we = sw; set_bits = sb; clr_we = cw; clr_bits = cb;
        srst_we = rw; srst_data = rd; stat_chg = sc; stat_code = code;
        start_sent = ss;
        exp_q.push_back({p, s, i, f});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare after each edge while items wait.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            logic [7:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {srst_pulse, slave_resp_en, irq, flags};
            checks++;
            if (a !== e) begin
                failures++;
                $display("FAIL %s: actual pulse/slv/irq/flags=%b expected=%b", t, a, e);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b00000,0,0,0, "R1 reset");
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b00000,0,0,0, "R1 reset hold");
        @(negedge clk); rst_n = 1'b1;
        step(1,5'h01,0,5'h00,0,8'h00,0,8'h00,0, 5'b00001,0,0,0, "R2 set enable");
        step(1,5'h08,0,5'h00,0,8'h00,0,8'h00,0, 5'b01001,0,1,0, "R2 R9 set ack keeps enable");
        step(1,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b01001,0,1,0, "R2 zero set mask");
        step(0,5'h00,1,5'h00,0,8'h00,0,8'h00,0, 5'b01001,0,1,0, "R3 zero clear mask");
        step(0,5'h00,0,5'h00,0,8'h00,1,8'h08,0, 5'b11001,0,1,0, "R5 status change raises");
        step(1,5'h02,0,5'h00,0,8'h00,0,8'h00,0, 5'b11011,1,1,0, "R6 irq on enable");
        step(0,5'h00,1,5'h10,0,8'h00,0,8'h00,0, 5'b01011,0,1,0, "R3 clear interrupt");
        step(0,5'h00,0,5'h00,0,8'h00,1,8'hF8,0, 5'b01011,0,1,0, "R5 idle code ignored");
        step(1,5'h04,0,5'h00,0,8'h00,0,8'h00,0, 5'b01111,0,1,0, "R2 set start");
        step(1,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b01111,0,1,0, "R7 zero write keeps start");
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,1, 5'b01011,0,1,0, "R7 start sent clears");
        step(1,5'h04,1,5'h04,0,8'h00,0,8'h00,0, 5'b01011,0,1,0, "R4 set+clear start");
        step(0,5'h00,1,5'h10,0,8'h00,1,8'h10,0, 5'b01011,0,1,0, "R4 hw set vs sw clear");
        step(0,5'h00,0,5'h00,0,8'h00,1,8'h18,0, 5'b11011,1,1,0, "R5 R6 raise again");
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b11011,1,1,0, "R5 interrupt sticky");
        step(1,5'h04,0,5'h00,0,8'h00,0,8'h00,1, 5'b11011,1,1,0, "R4 R7 set vs start sent");
        step(0,5'h00,1,5'h08,0,8'h00,0,8'h00,0, 5'b10011,1,0,0, "R9 drop ack");
        step(0,5'h00,0,5'h00,1,8'h06,0,8'h00,0, 5'b10011,1,0,0, "R8 wrong key ignored");
        step(0,5'h00,0,5'h00,1,8'h07,0,8'h00,0, 5'b00000,0,0,1, "R8 key wipes and pulses");
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b00000,0,0,0, "R8 pulse one cycle");
        step(1,5'h1F,0,5'h00,0,8'h00,0,8'h00,0, 5'b11111,1,1,0, "R2 set all");
        step(0,5'h00,1,5'h01,0,8'h00,0,8'h00,0, 5'b11110,1,0,0, "R9 R3 drop enable");
        step(1,5'h01,0,5'h00,1,8'h07,0,8'h00,0, 5'b00000,0,0,1, "R8 wipe beats set");
        step(0,5'h00,0,5'h00,0,8'h00,0,8'h00,0, 5'b00000,0,0,0, "R8 after wipe");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual left=%0d expected left=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule